// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one channel of a timer that owns a shared up or up/down counter elsewhere. The channel receives the counter value and its counting direction. It runs in one of four modes. In capture mode it watches an asynchronous pin and records the counter value when a chosen transition arrives. In compare mode it raises an event and toggles its pin when the counter reaches a programmed value. In the two pulse-width modes it shapes a pin waveform, either aligned to the counter wrap or centred on the counter's turning point.

Each mode reports through a single channel flag. The flag means something different in each mode: a capture happened, a compare matched, or a pulse edge was produced. An enable turns the flag into a level interrupt request. A separate flag-clear unit clears the flag with a one-cycle clear pulse. If an event arrives in the same cycle as the pulse, the event wins, so no event is lost.

Top module: `capcmp_channel`

## Requirements
- R1: While reset is high and on the first cycle after it, flag, irq, pin_out and cap_value are all zero.
- R2: In capture mode (mode = 2'b00) the edge selector picks the pin transition that triggers a capture: 2'b00 none, 2'b01 low-to-high, 2'b10 high-to-low, 2'b11 either.
- R3: The pin passes two synchronizer flops and one edge-history flop. A selected pin transition made between clock edges sets the flag, and loads cap_value with the counter value, on the third rising clock edge after the transition. The flag stays low after the first two edges.
- R4: In compare mode (mode = 2'b01), the flag is set on the clock edge at which cnt_value equals ch_value.
- R5: In compare mode, pin_out inverts on every clock edge at which cnt_value equals ch_value.
- R6: In edge-aligned pulse mode (mode = 2'b10), pin_out is cleared on an edge where cnt_value equals ch_value. Otherwise it is set on an edge where cnt_value is zero. With a counter running 0 to P-1, pin_out is high for min(ch_value, P) cycles per period.
- R7: In centre-aligned pulse mode (mode = 2'b11), a match while counting up (cnt_down = 0) clears pin_out and a match while counting down sets it. With a counter running 0 up to P and back down to 1, pin_out is high for 2*ch_value cycles per period when 0 < ch_value < P.
- R8: In both pulse modes, the flag is set by a counter match.
- R9: irq is high exactly when both the flag and irq_en are high, as a steady level.
- R10: A one-cycle flag_clr pulse clears the flag. If a flag-setting event occurs in the same cycle, the flag stays set.
- R11: Capture mode never changes pin_out. Compare and pulse modes never change cap_value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_value | input | CW | Shared counter value |
| cnt_down | input | 1 | Counter direction, 1 while counting down |
| mode | input | 2 | 00 capture, 01 compare, 10 edge-aligned pulse, 11 centre-aligned pulse |
| edge_sel | input | 2 | Capture trigger: 00 none, 01 rising, 10 falling, 11 both |
| ch_value | input | CW | Channel compare value |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear pulse from the flag-clear unit |
| pin_in | input | 1 | Asynchronous capture pin |
| pin_out | output | 1 | Channel output pin |
| cap_value | output | CW | Captured counter value |
| flag | output | 1 | Channel event flag |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions check several rules on every cycle. A compare or pulse-mode match is always followed by a set flag and by the pin level the mode calls for. A disabled edge selector never raises the flag. The captured value only moves in capture mode. The interrupt always follows flag and enable. Some behaviours appear only over whole counter periods or a full edge sequence, so only the bench scenarios can show them. These are the pulse duty cycles for every compare value, the exact three-edge capture latency for each selector and pin direction, and the clear-versus-event race.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    typedef enum logic [1:0] {
        MODE_CAPTURE    = 2'b00,
        MODE_COMPARE    = 2'b01,
        MODE_PWM_EDGE   = 2'b10,
        MODE_PWM_CENTER = 2'b11
    } ch_mode_e;

    typedef enum logic [1:0] {
        TRIG_NONE = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic capture;
        logic match;
    } ch_event_t;

    // Decides whether a synchronized level pair forms a selected transition.
    function automatic logic trig_hit(trig_sel_e sel, logic now_lvl, logic old_lvl);
        logic rise;
        logic fall;
        rise = now_lvl & ~old_lvl;
        fall = ~now_lvl & old_lvl;
        case (sel)
            TRIG_RISE: return rise;
            TRIG_FALL: return fall;
            TRIG_BOTH: return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/capcmp_pin_sync.sv
module capcmp_pin_sync
    import capcmp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_async,
    input  trig_sel_e sel,
    output logic      trig
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain;

    generate
        for (genvar i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    // Last synchronized level versus the one kept for edge history.
    always_comb trig = trig_hit(sel, chain[STAGES-1], chain[STAGES]);

endmodule

// File: rtl/capcmp_out_ctl.sv
module capcmp_out_ctl
    import capcmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  ch_mode_e      mode,
    input  logic [CW-1:0] cnt_value,
    input  logic          cnt_down,
    input  logic [CW-1:0] ch_value,
    output logic          match,
    output logic          pin_out
);
    localparam logic [CW-1:0] ZERO = '0;

    logic pin_q;
    logic pin_d;

    always_comb match = (cnt_value == ch_value);

    always_comb begin
        pin_d = pin_q;
        case (mode)
            MODE_COMPARE: begin
                if (match) pin_d = ~pin_q;
            end
            MODE_PWM_EDGE: begin
                if (match)                   pin_d = 1'b0;
                else if (cnt_value == ZERO)  pin_d = 1'b1;
            end
            MODE_PWM_CENTER: begin
                if (match) pin_d = cnt_down;
            end
            default: pin_d = pin_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_d;
    end

    assign pin_out = pin_q;

endmodule

// File: rtl/capcmp_flag.sv
module capcmp_flag
    import capcmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  ch_event_t     evt,
    input  logic          clr,
    input  logic [CW-1:0] cnt_value,
    output logic          flag,
    output logic [CW-1:0] cap_value
);
    logic set;

    always_comb set = evt.capture | evt.match;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag      <= 1'b0;
            cap_value <= '0;
        end else begin
            flag <= set | (flag & ~clr);
            if (evt.capture) cap_value <= cnt_value;
        end
    end

endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
    import capcmp_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_value,
    input  logic          cnt_down,
    input  logic [1:0]    mode,
    input  logic [1:0]    edge_sel,
    input  logic [CW-1:0] ch_value,
    input  logic          irq_en,
    input  logic          flag_clr,
    input  logic          pin_in,
    output logic          pin_out,
    output logic [CW-1:0] cap_value,
    output logic          flag,
    output logic          irq
);
    ch_mode_e  mode_e;
    trig_sel_e sel_e;
    logic      trig;
    logic      match;
    ch_event_t evt;

    always_comb begin
        mode_e = ch_mode_e'(mode);
        sel_e  = trig_sel_e'(edge_sel);
    end

    capcmp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_async(pin_in),
        .sel      (sel_e),
        .trig     (trig)
    );

    capcmp_out_ctl #(.CW(CW)) u_out (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_e),
        .cnt_value(cnt_value),
        .cnt_down (cnt_down),
        .ch_value (ch_value),
        .match    (match),
        .pin_out  (pin_out)
    );

    always_comb begin
        evt.capture = (mode_e == MODE_CAPTURE) & trig;
        evt.match   = (mode_e != MODE_CAPTURE) & match;
    end

    capcmp_flag #(.CW(CW)) u_flag (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr      (flag_clr),
        .cnt_value(cnt_value),
        .flag     (flag),
        .cap_value(cap_value)
    );

    assign irq = flag & irq_en;

endmodule

// File: rtl/capcmp_channel_checker.sv
module capcmp_channel_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] cnt_value,
    input logic          cnt_down,
    input logic [1:0]    mode,
    input logic [1:0]    edge_sel,
    input logic [CW-1:0] ch_value,
    input logic          irq_en,
    input logic          pin_out,
    input logic [CW-1:0] cap_value,
    input logic          flag,
    input logic          irq
);
    assert_cmp_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && cnt_value == ch_value) |=> flag);

    assert_pwm_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && cnt_value == ch_value) |=> flag);

    assert_epwm_low_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && cnt_value == ch_value) |=> !pin_out);

    assert_epwm_high_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && cnt_value == '0 && ch_value != '0) |=> pin_out);

    assert_cpwm_up_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && cnt_value == ch_value && !cnt_down) |=> !pin_out);

    assert_cpwm_down_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && cnt_value == ch_value && cnt_down) |=> pin_out);

    assert_trig_off_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && edge_sel == 2'b00 && !flag) |=> !flag);

    assert_cap_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00) |=> $stable(cap_value));

    assert_pin_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> $stable(pin_out));

    assert_irq_off_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    assert_irq_on_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_en && flag) |-> irq);

endmodule

bind capcmp_channel capcmp_channel_checker #(.CW(CW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_value(cnt_value),
    .cnt_down (cnt_down),
    .mode     (mode),
    .edge_sel (edge_sel),
    .ch_value (ch_value),
    .irq_en   (irq_en),
    .pin_out  (pin_out),
    .cap_value(cap_value),
    .flag     (flag),
    .irq      (irq)
);

// File: tb/test_capcmp_channel.sv
`timescale 1ns/1ps
module test_capcmp_channel;
    localparam int CW = 16;
    localparam int P  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cnt_value = '0;
    logic          cnt_down = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [1:0]    edge_sel = 2'b00;
    logic [CW-1:0] ch_value = '0;
    logic          irq_en = 1'b0;
    logic          flag_clr = 1'b0;
    logic          pin_in = 1'b0;
    logic          pin_out;
    logic [CW-1:0] cap_value;
    logic          flag;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    capcmp_channel #(.CW(CW)) i_capcmp_channel (
        .clk(clk), .rst(rst), .cnt_value(cnt_value), .cnt_down(cnt_down),
        .mode(mode), .edge_sel(edge_sel), .ch_value(ch_value), .irq_en(irq_en),
        .flag_clr(flag_clr), .pin_in(pin_in), .pin_out(pin_out),
        .cap_value(cap_value), .flag(flag), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] cap_old;
        logic          pin_keep;
        logic [CW-1:0] cap_keep;
        int            highs;
        int            bad;

        step(); step();
        check("R1 flag", flag, 0);
        check("R1 irq", irq, 0);
        check("R1 pin_out", pin_out, 0);
        check("R1 cap_value", cap_value, 0);
        rst = 1'b0;
        step();
        check("R1 flag after release", flag, 0);
        check("R1 cap after release", cap_value, 0);

        // Capture sweep: every selector, both pin directions (R2, R3, R11).
        mode = 2'b00;
        pin_keep = pin_out;
        for (int sel = 0; sel < 4; sel++) begin
            for (int dir = 0; dir < 2; dir++) begin
                logic [CW-1:0] v;
                bit            expect_hit;
                v = 16'h1000 + 16'(sel * 16 + dir * 3 + 1);
                edge_sel = 2'(sel);
                cnt_value = 16'h0F0F;
                pin_in = (dir == 1);
                repeat (4) step();
                clear_flag();
                cap_old = cap_value;
                cnt_value = v;
                pin_in = (dir == 0);
                expect_hit = (sel == 3) || (sel == 1 && dir == 0) || (sel == 2 && dir == 1);
                step(); step();
                check("R3 flag low before third edge", flag, 0);
                step();
                check("R2 R3 flag per selector", flag, expect_hit);
                check("R3 captured value", cap_value, expect_hit ? v : cap_old);
            end
        end
        check("R11 pin_out unchanged in capture", pin_out, pin_keep);

        // Compare sweep over every match position (R4, R5).
        cap_keep = cap_value;
        mode = 2'b01;
        for (int k = 0; k < P; k++) begin
            logic pin_before;
            ch_value = 16'(k);
            cnt_value = 16'(P);
            clear_flag();
            pin_before = pin_out;
            bad = 0;
            for (int c = 0; c < P; c++) begin
                cnt_value = 16'(c);
                step();
                if (flag !== (c >= k)) bad++;
            end
            check("R4 compare flag timing", bad, 0);
            check("R5 compare pin toggle", pin_out, !pin_before);
        end

        // Edge-aligned pulse duty for every compare value (R6).
        mode = 2'b10;
        for (int k = 0; k <= P; k++) begin
            ch_value = 16'(k);
            for (int w = 0; w < 2 * P; w++) begin
                cnt_value = 16'(w % P);
                step();
            end
            highs = 0;
            for (int c = 0; c < P; c++) begin
                cnt_value = 16'(c);
                step();
                if (pin_out) highs++;
            end
            check("R6 edge pulse duty", highs, (k < P) ? k : P);
        end

        // Pulse-mode flag (R8).
        ch_value = 16'd3;
        cnt_value = 16'(P);
        clear_flag();
        check("R8 flag cleared", flag, 0);
        for (int c = 0; c < P; c++) begin
            cnt_value = 16'(c);
            step();
        end
        check("R8 edge pulse flag", flag, 1);

        // Centre-aligned pulse duty (R7).
        mode = 2'b11;
        for (int k = 1; k < P; k++) begin
            ch_value = 16'(k);
            highs = 0;
            for (int rep = 0; rep < 2; rep++) begin
                for (int i = 0; i < 2 * P; i++) begin
                    cnt_value = (i <= P) ? 16'(i) : 16'(2 * P - i);
                    cnt_down  = (i > P);
                    step();
                    if (rep == 1 && pin_out) highs++;
                end
            end
            check("R7 centre pulse duty", highs, 2 * k);
        end
        cnt_down = 1'b0;
        ch_value = 16'd2;
        cnt_value = 16'(P);
        clear_flag();
        cnt_value = 16'd2;
        step();
        check("R8 centre pulse flag", flag, 1);
        check("R11 cap unchanged outside capture", cap_value, cap_keep);

        // Clear race and interrupt (R9, R10).
        mode = 2'b01;
        ch_value = 16'd5;
        cnt_value = 16'd5;
        step();
        check("R10 flag set by match", flag, 1);
        irq_en = 1'b0;
        #1;
        check("R9 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        check("R9 irq follows flag", irq, 1);
        flag_clr = 1'b1;
        step();
        check("R10 event wins over clear", flag, 1);
        cnt_value = 16'd6;
        step();
        flag_clr = 1'b0;
        check("R10 clear takes effect", flag, 0);
        check("R9 irq drops with flag", irq, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule